// File: doc/BRIEF.md
# Keyboard Serial Receive Controller

This block takes in frames from a keyboard that talks over two open-drain wires, one carrying a clock and one carrying data. Both wires arrive as raw, asynchronous levels. Each wire passes through a two-stage synchronizer and then a glitch filter. The filter accepts a new level only after it has stayed put for a configurable number of system clocks. A falling edge on the filtered clock samples the filtered data. A frame opens with a low start bit. Eight data bits follow, least significant first, then an odd parity bit and a closing stop bit.

The host works with a handful of level and pulse signals. It turns on the line interface with an I/O enable. It then requests receive mode, and that request is honoured only while both filtered lines read high, which means the bus is idle. When the stop bit arrives, the byte, a parity-error flag and a stop-bit flag are latched and a buffer-full flag is raised. At the same moment the block starts pulling the clock wire low through an open-drain enable, so the keyboard cannot send more. If interrupts are enabled, an interrupt request appears together with buffer-full. When the host clears buffer-full, the clock wire is released and the next frame can come in.

Two features keep noise from corrupting frames. A start bit sampled high is treated as noise and dropped without touching any flag. If no falling edge arrives within a timeout while a frame is in progress, the partial frame is thrown away and the receiver waits for a new start bit.

Top module: `kbd_rx_ctrl`

## Requirements
- R1: After reset, rx_en_o, buf_full_o, kb_clk_pull_o, irq_o, par_err_o and stop_ok_o are 0, and rx_byte_o is 8'h00.
- R2: A pulse on rx_en_set_i sets rx_en_o in the next cycle only when io_en_i is 1 and line_clk_o and line_dat_o are both 1; in every other case the request is dropped. While io_en_i is 0, rx_en_o is cleared in the next cycle.
- R3: Data bits are sampled on falling edges of the filtered clock, least significant bit first, and the eight bits after the start bit appear on rx_byte_o.
- R4: par_err_o is latched as 1 when the eight data bits together with the parity bit hold an even number of ones, and as 0 when they hold an odd number.
- R5: stop_ok_o is latched as the level of the data line sampled on the eleventh falling clock edge of the frame (the stop bit).
- R6: On the cycle the stop bit is taken, buf_full_o goes to 1, and kb_clk_pull_o is 1 for as long as buf_full_o is 1.
- R7: irq_o is 1 exactly when buf_full_o is 1 and irq_en_i is 1.
- R8: A pulse on buf_clr_i clears buf_full_o in the next cycle and releases kb_clk_pull_o, and the next frame is then received normally.
- R9: No frame is taken while rx_en_o is 0 or buf_full_o is 1: buf_full_o and rx_byte_o keep their values.
- R10: A falling edge that samples the data line high while no frame is in progress sets no flag and does not start a frame.
- R11: If TIMEOUT_CYC cycles pass without a falling edge in the middle of a frame, the partial frame is dropped and the receiver waits for a new start bit.
- R12: A pulse on either raw line that lasts fewer than FILT_LEN system clocks has no effect on the filtered levels or on frame reception.
- R13: line_clk_o and line_dat_o show the filtered levels of the two raw inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Raw level of the keyboard clock wire |
| kb_dat_i | input | 1 | Raw level of the keyboard data wire |
| kb_clk_pull_o | output | 1 | Open-drain enable; 1 pulls the clock wire low |
| io_en_i | input | 1 | Line interface enable |
| rx_en_set_i | input | 1 | Pulse requesting receive mode |
| irq_en_i | input | 1 | Interrupt enable |
| buf_clr_i | input | 1 | Pulse clearing the buffer-full flag |
| rx_en_o | output | 1 | Receive mode active |
| buf_full_o | output | 1 | A received byte is waiting |
| rx_byte_o | output | 8 | Last received byte |
| par_err_o | output | 1 | Parity error of the last frame |
| stop_ok_o | output | 1 | Stop bit of the last frame was 1 |
| irq_o | output | 1 | Interrupt request |
| line_clk_o | output | 1 | Filtered clock wire level |
| line_dat_o | output | 1 | Filtered data wire level |

## Verification
The bench builds the block with FILT_LEN = 3 and TIMEOUT_CYC = 400. At these values a one- or two-cycle glitch can be placed right at the filter's threshold, and a partial frame can outlive the timeout in a few hundred cycles. Each keyboard half period is 12 cycles, so a complete frame takes about 300 cycles. That is short enough for the bench to send every byte value from 0 to 255 with correct parity and check each one. It also sends a set of frames with a flipped parity bit and frames with a low stop bit.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    typedef logic [7:0] kbd_byte_t;

    typedef enum logic {
        RX_IDLE  = 1'b0,
        RX_SHIFT = 1'b1
    } rx_state_e;

    // frame position: 1..8 data, 9 parity, 10 stop
    typedef struct packed {
        rx_state_e state;
        logic [3:0] pos;
        kbd_byte_t  shreg;
        logic       par;
        logic       clk_prev;
    } shift_regs_t;

    typedef struct packed {
        logic      rx_en;
        logic      buf_full;
        kbd_byte_t data;
        logic      par_err;
        logic      stop_ok;
    } ctrl_regs_t;

endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int unsigned CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          level;
        logic [CW-1:0] cnt;
    } filt_regs_t;

    filt_regs_t q, d;

    always_comb begin
        d       = q;
        d.sync1 = raw_i;
        d.sync2 = q.sync1;
        if (q.sync2 != q.level) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.level = q.sync2;
                d.cnt   = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync1 <= 1'b1;
            q.sync2 <= 1'b1;
            q.level <= 1'b1;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.level;

endmodule

// File: rtl/kbd_frame_shift.sv
module kbd_frame_shift
    import kbd_rx_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 100000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      line_clk_i,
    input  logic      line_dat_i,
    output logic      done_o,
    output kbd_byte_t byte_o,
    output logic      par_err_o,
    output logic      stop_o
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

    shift_regs_t q, d;
    logic [TW-1:0] to_q, to_d;
    logic fall;

    assign fall = q.clk_prev & ~line_clk_i;

    always_comb begin
        d          = q;
        to_d       = to_q;
        done_o     = 1'b0;
        d.clk_prev = line_clk_i;
        if (!en_i) begin
            d.state = RX_IDLE;
            d.pos   = '0;
            to_d    = '0;
        end else begin
            unique case (q.state)
                RX_IDLE: begin
                    to_d = '0;
                    if (fall && !line_dat_i) begin
                        d.state = RX_SHIFT;
                        d.pos   = 4'd1;
                    end
                end
                RX_SHIFT: begin
                    if (fall) begin
                        to_d  = '0;
                        d.pos = q.pos + 4'd1;
                        if (q.pos <= 4'd8) begin
                            d.shreg = {line_dat_i, q.shreg[7:1]};
                        end else if (q.pos == 4'd9) begin
                            d.par = line_dat_i;
                        end else begin
                            done_o  = 1'b1;
                            d.state = RX_IDLE;
                            d.pos   = '0;
                        end
                    end else if (to_q == TW'(TIMEOUT_CYC - 1)) begin
                        d.state = RX_IDLE;
                        d.pos   = '0;
                        to_d    = '0;
                    end else begin
                        to_d = to_q + 1'b1;
                    end
                end
                default: d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= RX_IDLE;
            q.pos      <= '0;
            q.shreg    <= '0;
            q.par      <= 1'b0;
            q.clk_prev <= 1'b1;
            to_q       <= '0;
        end else begin
            q    <= d;
            to_q <= to_d;
        end
    end

    assign byte_o    = q.shreg;
    assign par_err_o = ~(^{q.shreg, q.par});
    assign stop_o    = line_dat_i;

endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
    import kbd_rx_pkg::*;
#(
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    output logic       kb_clk_pull_o,
    input  logic       io_en_i,
    input  logic       rx_en_set_i,
    input  logic       irq_en_i,
    input  logic       buf_clr_i,
    output logic       rx_en_o,
    output logic       buf_full_o,
    output logic [7:0] rx_byte_o,
    output logic       par_err_o,
    output logic       stop_ok_o,
    output logic       irq_o,
    output logic       line_clk_o,
    output logic       line_dat_o
);
    localparam int unsigned NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;

    assign raw = {kb_dat_i, kb_clk_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        kbd_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[g]),
            .level_o(lvl[g])
        );
    end

    ctrl_regs_t q, d;
    logic      fr_done;
    kbd_byte_t fr_byte;
    logic      fr_par_err;
    logic      fr_stop;
    logic      shift_en;

    assign shift_en = q.rx_en & ~q.buf_full;

    kbd_frame_shift #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (shift_en),
        .line_clk_i(lvl[0]),
        .line_dat_i(lvl[1]),
        .done_o    (fr_done),
        .byte_o    (fr_byte),
        .par_err_o (fr_par_err),
        .stop_o    (fr_stop)
    );

    always_comb begin
        d = q;
        if (!io_en_i) begin
            d.rx_en = 1'b0;
        end else if (rx_en_set_i && lvl[0] && lvl[1]) begin
            d.rx_en = 1'b1;
        end
        if (buf_clr_i) begin
            d.buf_full = 1'b0;
        end
        if (fr_done && shift_en) begin
            d.buf_full = 1'b1;
            d.data     = fr_byte;
            d.par_err  = fr_par_err;
            d.stop_ok  = fr_stop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign kb_clk_pull_o = q.buf_full;
    assign rx_en_o       = q.rx_en;
    assign buf_full_o    = q.buf_full;
    assign rx_byte_o     = q.data;
    assign par_err_o     = q.par_err;
    assign stop_ok_o     = q.stop_ok;
    assign irq_o         = q.buf_full & irq_en_i;
    assign line_clk_o    = lvl[0];
    assign line_dat_o    = lvl[1];

endmodule

// File: rtl/kbd_rx_ctrl_chk.sv
module kbd_rx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       io_en_i,
    input logic       rx_en_set_i,
    input logic       irq_en_i,
    input logic       buf_clr_i,
    input logic       rx_en_o,
    input logic       buf_full_o,
    input logic [7:0] rx_byte_o,
    input logic       irq_o,
    input logic       line_clk_o,
    input logic       line_dat_o
);
    p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en_o) |-> $past(io_en_i && rx_en_set_i && line_clk_o && line_dat_o));

    p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_en_i |=> !rx_en_o);

    p_full_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full_o) |-> $past(rx_en_o));

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en_i && buf_full_o));

    p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_clr_i && buf_full_o) |=> !buf_full_o);

    p_hold_while_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full_o && !buf_clr_i) |=> (buf_full_o && $stable(rx_byte_o)));

endmodule

bind kbd_rx_ctrl kbd_rx_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_en_i    (io_en_i),
    .rx_en_set_i(rx_en_set_i),
    .irq_en_i   (irq_en_i),
    .buf_clr_i  (buf_clr_i),
    .rx_en_o    (rx_en_o),
    .buf_full_o (buf_full_o),
    .rx_byte_o  (rx_byte_o),
    .irq_o      (irq_o),
    .line_clk_o (line_clk_o),
    .line_dat_o (line_dat_o)
);

// File: tb/kbd_rx_ctrl_test.sv
`timescale 1ns/1ps
module kbd_rx_ctrl_test;
    localparam int H = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kb_clk_drv = 1'b1;
    logic kb_dat_drv = 1'b1;
    logic io_en = 1'b0, rx_en_set = 1'b0, irq_en = 1'b0, buf_clr = 1'b0;
    logic pull, rx_en, buf_full, par_err, stop_ok, irq, line_clk, line_dat;
    logic [7:0] rx_byte;
    logic kb_clk_wire;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign kb_clk_wire = kb_clk_drv & ~pull;

    kbd_rx_ctrl #(.FILT_LEN(3), .TIMEOUT_CYC(400)) uut (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_wire), .kb_dat_i(kb_dat_drv),
        .kb_clk_pull_o(pull), .io_en_i(io_en), .rx_en_set_i(rx_en_set),
        .irq_en_i(irq_en), .buf_clr_i(buf_clr), .rx_en_o(rx_en),
        .buf_full_o(buf_full), .rx_byte_o(rx_byte), .par_err_o(par_err),
        .stop_ok_o(stop_ok), .irq_o(irq), .line_clk_o(line_clk), .line_dat_o(line_dat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit par_bad, input bit stop_v);
        return {stop_v, (~^b) ^ par_bad, b, 1'b0};
    endfunction

    task automatic kb_bits(input logic [10:0] fr, input int n);
        for (int i = 0; i < n; i++) begin
            kb_dat_drv = fr[i];
            repeat (H) @(negedge clk);
            kb_clk_drv = 1'b0;
            repeat (H) @(negedge clk);
            kb_clk_drv = 1'b1;
        end
        kb_dat_drv = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic pulse_set();
        rx_en_set = 1'b1; @(negedge clk); rx_en_set = 1'b0; @(negedge clk);
    endtask

    task automatic clear_buf();
        buf_clr = 1'b1; @(negedge clk); buf_clr = 1'b0; @(negedge clk);
        check("R8 buf_full cleared", buf_full, 0);
        check("R8 pull released", pull, 0);
        check("R8 irq dropped", irq, 0);
        repeat (H) @(negedge clk);
    endtask

    task automatic expect_frame(input logic [7:0] b, input bit pe, input bit st, input bit ie);
        check("R6 buf_full set", buf_full, 1);
        check("R6 pull asserted", pull, 1);
        check("R3 byte", rx_byte, b);
        check("R4 parity flag", par_err, pe);
        check("R5 stop flag", stop_ok, st);
        check("R7 irq", irq, ie);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx_en", rx_en, 0);
        check("R1 buf_full", buf_full, 0);
        check("R1 pull", pull, 0);
        check("R1 irq", irq, 0);
        check("R1 par_err", par_err, 0);
        check("R1 stop_ok", stop_ok, 0);
        check("R1 byte", rx_byte, 0);
        repeat (8) @(negedge clk);
        check("R13 clk idle high", line_clk, 1);
        check("R13 dat idle high", line_dat, 1);

        // R2: request dropped while io disabled
        pulse_set();
        check("R2 no enable without io_en", rx_en, 0);
        io_en = 1'b1;
        kb_dat_drv = 1'b0;
        repeat (10) @(negedge clk);
        check("R13 dat low seen", line_dat, 0);
        pulse_set();
        check("R2 no enable with data low", rx_en, 0);
        kb_dat_drv = 1'b1;
        repeat (10) @(negedge clk);
        // R9: frame ignored while not enabled
        kb_bits(mk_frame(8'h96, 0, 1), 11);
        check("R9 no frame while disabled", buf_full, 0);
        check("R9 byte untouched", rx_byte, 0);
        pulse_set();
        check("R2 enabled on idle bus", rx_en, 1);

        // R3..R8: every byte value
        for (int v = 0; v < 256; v++) begin
            irq_en = v[0];
            kb_bits(mk_frame(8'(v), 0, 1), 11);
            expect_frame(8'(v), 0, 1, v[0]);
            clear_buf();
        end

        // R4: flipped parity
        for (int v = 0; v < 16; v++) begin
            logic [7:0] b;
            b = 8'(v * 17 + 3);
            kb_bits(mk_frame(b, 1, 1), 11);
            expect_frame(b, 1, 1, irq_en);
            clear_buf();
        end

        // R5: stop bit low
        for (int v = 0; v < 4; v++) begin
            logic [7:0] b;
            b = 8'(8'hC1 + v);
            kb_bits(mk_frame(b, 0, 0), 11);
            expect_frame(b, 0, 0, irq_en);
            clear_buf();
        end

        // R9: frame while full is blocked
        kb_bits(mk_frame(8'h3E, 0, 1), 11);
        expect_frame(8'h3E, 0, 1, irq_en);
        kb_bits(mk_frame(8'hD4, 0, 1), 11);
        check("R9 still full", buf_full, 1);
        check("R9 byte kept while full", rx_byte, 8'h3E);
        clear_buf();
        // R8: next frame after clear
        kb_bits(mk_frame(8'h71, 0, 1), 11);
        expect_frame(8'h71, 0, 1, irq_en);
        check("R8 frame after clear", rx_byte, 8'h71);
        clear_buf();

        // R10: start bit sampled high
        kb_bits(11'h7FF, 1);
        repeat (30) @(negedge clk);
        check("R10 no flag on high start", buf_full, 0);
        kb_bits(mk_frame(8'hA5, 0, 1), 11);
        check("R10 following frame byte", rx_byte, 8'hA5);
        expect_frame(8'hA5, 0, 1, irq_en);
        clear_buf();

        // R11: partial frame then timeout
        kb_bits(mk_frame(8'hFF, 0, 1), 5);
        repeat (500) @(negedge clk);
        check("R11 partial frame dropped", buf_full, 0);
        kb_bits(mk_frame(8'h3C, 0, 1), 11);
        check("R11 frame after timeout", rx_byte, 8'h3C);
        expect_frame(8'h3C, 0, 1, irq_en);
        clear_buf();

        // R12: short clock glitches with data low
        kb_dat_drv = 1'b0;
        repeat (H) @(negedge clk);
        kb_clk_drv = 1'b0; @(negedge clk); kb_clk_drv = 1'b1;
        repeat (4) @(negedge clk);
        kb_clk_drv = 1'b0; repeat (2) @(negedge clk); kb_clk_drv = 1'b1;
        repeat (2) @(negedge clk);
        check("R12 filtered clk unchanged", line_clk, 1);
        kb_dat_drv = 1'b1;
        repeat (H) @(negedge clk);
        kb_bits(mk_frame(8'h5A, 0, 1), 11);
        check("R12 frame after glitches", rx_byte, 8'h5A);
        expect_frame(8'h5A, 0, 1, irq_en);
        clear_buf();

        // R2: dropping io_en clears receive mode
        io_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 io_en low clears", rx_en, 0);
        kb_bits(mk_frame(8'h11, 0, 1), 11);
        check("R9 disabled after io off", buf_full, 0);
        check("R9 byte kept after io off", rx_byte, 8'h5A);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule